// File: doc/BRIEF.md
# Multithreaded Commit Thread Selector

In a core that keeps several hardware threads in flight, the retire stage has to decide, for each commit slot, which thread is allowed to retire the oldest entry of its reorder buffer. This block makes that decision. For every thread it looks at five inputs: an active bit, a commit-state code, a buffer-empty flag, a head-ready flag and the head sequence number. It then returns a valid flag and the index of the winning thread.

A two-bit mode input chooses the arbitration rule. The rotating rule keeps a registered ordering of thread indices. It picks the first thread in that ordering that is usable and has a ready head. When the retire stage asserts the take strobe, the winner moves to the back of the ordering. The age rule picks, among usable threads with a non-empty buffer and a ready head, the thread whose head carries the smallest sequence number. The greedy mode selects the same way as the age rule.

When the block is built for a single thread it reduces to a simple gate: thread 0 is offered whenever it is active and in a usable state. In that build the caller checks head readiness itself. The selection path is combinational, so one answer is available in the same cycle for each commit slot. The retire stage strobes once for each slot it actually fills.

Top module: `commit_thread_select`

## Requirements
- R1: A thread is usable only when its 3-bit state code is 0 (idle), 1 (running) or 4 (waiting on a fetch-side trap). Codes 2 (buffer squashing), 3 (trap pending) and 5 to 7 are never selected.
- R2: A thread whose `thread_active` bit is 0 is never selected, under any mode.
- R3: In mode 1 (rotating), the output is the first thread in the registered ordering that is usable and has `head_ready` set. After reset the ordering is 0, 1, ..., N-1 from front to back.
- R4: In mode 1, when `select_stb` is high and a winner exists, the next clock edge removes the winner from its place in the ordering. The threads behind it each move one place forward, and the winner goes to the back.
- R5: The ordering does not change on a clock edge unless the mode is 1, `select_stb` is high and a winner exists.
- R6: In mode 2 (age), the output is the usable thread with `rob_empty` low and `head_ready` high whose `head_seq` is smallest. Sequence numbers compare as unsigned values.
- R7: In mode 2, when two candidate sequence numbers are equal, the lower thread index wins.
- R8: Mode 0 (greedy) and mode 3 give exactly the same result as mode 2.
- R9: When no thread qualifies, `pick_valid` is 0 and `pick_tid` is 0.
- R10: With `NUM_THREADS` = 1, the block outputs thread 0 as valid whenever it is active and usable, regardless of `head_ready`, `rob_empty` and the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_sel | input | 2 | Arbitration mode: 0 greedy, 1 rotating, 2 age, 3 treated as age |
| thread_active | input | NUM_THREADS | Per-thread active bit |
| thread_status | input | 3*NUM_THREADS | Per-thread commit-state code, thread k in bits [3k+2:3k] |
| rob_empty | input | NUM_THREADS | Per-thread reorder-buffer empty flag |
| head_ready | input | NUM_THREADS | Per-thread head-ready-to-retire flag |
| head_seq | input | SEQ_W*NUM_THREADS | Per-thread head sequence number, thread k in slice k |
| select_stb | input | 1 | The current pick is being consumed by a commit slot |
| pick_valid | output | 1 | A thread was selected |
| pick_tid | output | TID_W | Index of the selected thread |

## Verification
On every cycle, the assertions check that any selected thread is active and in a usable state. They check that a rotating pick has a ready head and that an age pick has no older or equal-and-lower-index rival. They also check that the ordering is always a permutation, that it only moves on a consumed rotating pick, and that an empty result reports thread 0. The exact reordering after a take cannot be seen from a single cycle, nor can the equivalence of the greedy and age modes or the single-thread gate that skips readiness. Only the bench's scenarios show those, by driving sequences of strobes and comparing each pick against the expected ordering.

// File: rtl/commit_sel_pkg.sv
package commit_sel_pkg;

  typedef enum logic [2:0] {
    TS_IDLE       = 3'd0,
    TS_RUNNING    = 3'd1,
    TS_ROB_SQUASH = 3'd2,
    TS_TRAP_WAIT  = 3'd3,
    TS_FETCH_TRAP = 3'd4
  } thr_state_e;

  typedef enum logic [1:0] {
    POL_GREEDY = 2'd0,
    POL_ROTATE = 2'd1,
    POL_AGE    = 2'd2,
    POL_ALT    = 2'd3
  } commit_pol_e;

  localparam int unsigned STATE_W = 3;

  // A thread may offer its head to commit only in these states.
  function automatic logic state_usable(input logic [STATE_W-1:0] s);
    return (s == TS_IDLE) || (s == TS_RUNNING) || (s == TS_FETCH_TRAP);
  endfunction

endpackage

// File: rtl/csel_qualify.sv
module csel_qualify
  import commit_sel_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 4
) (
  input  logic [NUM_THREADS-1:0]         thread_active,
  input  logic [STATE_W*NUM_THREADS-1:0] thread_status,
  input  logic [NUM_THREADS-1:0]         rob_empty,
  input  logic [NUM_THREADS-1:0]         head_ready,
  output logic [NUM_THREADS-1:0]         rot_cand,
  output logic [NUM_THREADS-1:0]         age_cand
);

  logic [NUM_THREADS-1:0] usable;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    assign usable[t]   = thread_active[t] &&
                         state_usable(thread_status[t*STATE_W +: STATE_W]);
    assign rot_cand[t] = usable[t] && head_ready[t];
    assign age_cand[t] = usable[t] && head_ready[t] && !rob_empty[t];
  end

endmodule

// File: rtl/csel_rotate_order.sv
module csel_rotate_order #(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned TID_W       = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_THREADS-1:0]       cand,
  input  logic                         advance,
  output logic                         hit,
  output logic [TID_W-1:0]             hit_tid,
  output logic [NUM_THREADS*TID_W-1:0] order_flat
);

  logic [TID_W-1:0] order_q [NUM_THREADS];
  logic [TID_W-1:0] order_d [NUM_THREADS];
  logic [TID_W-1:0] slot_c;
  logic             order_en;

  // Front-to-back scan of the ordering for the first candidate.
  always_comb begin
    hit     = 1'b0;
    slot_c  = '0;
    hit_tid = '0;
    for (int k = 0; k < NUM_THREADS; k++) begin
      if (!hit && cand[order_q[k]]) begin
        hit     = 1'b1;
        slot_c  = k[TID_W-1:0];
        hit_tid = order_q[k];
      end
    end
  end

  assign order_en = advance && hit;

  // Close the gap left by the winner, then append it at the back.
  always_comb begin
    for (int k = 0; k < NUM_THREADS; k++) order_d[k] = order_q[k];
    for (int k = 0; k < NUM_THREADS - 1; k++) begin
      if (k >= int'(slot_c)) order_d[k] = order_q[k+1];
    end
    order_d[NUM_THREADS-1] = hit_tid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_THREADS; k++) order_q[k] <= k[TID_W-1:0];
    end else if (order_en) begin
      for (int k = 0; k < NUM_THREADS; k++) order_q[k] <= order_d[k];
    end
  end

  for (genvar k = 0; k < NUM_THREADS; k++) begin : g_flat
    assign order_flat[k*TID_W +: TID_W] = order_q[k];
  end

endmodule

// File: rtl/csel_age_pick.sv
module csel_age_pick #(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned SEQ_W       = 16,
  parameter int unsigned TID_W       = 2
) (
  input  logic [NUM_THREADS-1:0]       cand,
  input  logic [SEQ_W*NUM_THREADS-1:0] head_seq,
  output logic                         found,
  output logic [TID_W-1:0]             found_tid
);

  logic [SEQ_W-1:0] best_seq;

  // Strictly-smaller replacement keeps the lower index on a tie.
  always_comb begin
    found     = 1'b0;
    found_tid = '0;
    best_seq  = '0;
    for (int k = 0; k < NUM_THREADS; k++) begin
      if (cand[k] && (!found || (head_seq[k*SEQ_W +: SEQ_W] < best_seq))) begin
        found     = 1'b1;
        best_seq  = head_seq[k*SEQ_W +: SEQ_W];
        found_tid = k[TID_W-1:0];
      end
    end
  end

endmodule

// File: rtl/commit_thread_select.sv
module commit_thread_select
  import commit_sel_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned SEQ_W       = 16,
  parameter int unsigned TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [1:0]                     policy_sel,
  input  logic [NUM_THREADS-1:0]         thread_active,
  input  logic [3*NUM_THREADS-1:0]       thread_status,
  input  logic [NUM_THREADS-1:0]         rob_empty,
  input  logic [NUM_THREADS-1:0]         head_ready,
  input  logic [SEQ_W*NUM_THREADS-1:0]   head_seq,
  input  logic                           select_stb,
  output logic                           pick_valid,
  output logic [TID_W-1:0]               pick_tid
);

  logic [NUM_THREADS*TID_W-1:0] rr_order_flat;

  if (NUM_THREADS == 1) begin : g_single
    // Single-thread shortcut: the caller checks head readiness itself.
    logic unused_ok;
    assign unused_ok = ^{clk, rst_n, policy_sel, rob_empty, head_ready,
                         head_seq, select_stb};
    assign pick_valid    = thread_active[0] && state_usable(thread_status[2:0]);
    assign pick_tid      = '0;
    assign rr_order_flat = '0;
  end else begin : g_multi
    logic [NUM_THREADS-1:0] rot_cand;
    logic [NUM_THREADS-1:0] age_cand;
    logic                   rot_hit;
    logic [TID_W-1:0]       rot_tid;
    logic                   age_hit;
    logic [TID_W-1:0]       age_tid;
    logic                   rot_mode;

    assign rot_mode = (policy_sel == POL_ROTATE);

    csel_qualify #(.NUM_THREADS(NUM_THREADS)) u_qual (
      .thread_active (thread_active),
      .thread_status (thread_status),
      .rob_empty     (rob_empty),
      .head_ready    (head_ready),
      .rot_cand      (rot_cand),
      .age_cand      (age_cand)
    );

    csel_rotate_order #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_rot (
      .clk        (clk),
      .rst_n      (rst_n),
      .cand       (rot_cand),
      .advance    (select_stb && rot_mode),
      .hit        (rot_hit),
      .hit_tid    (rot_tid),
      .order_flat (rr_order_flat)
    );

    csel_age_pick #(.NUM_THREADS(NUM_THREADS), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_age (
      .cand      (age_cand),
      .head_seq  (head_seq),
      .found     (age_hit),
      .found_tid (age_tid)
    );

    // Greedy and the spare code share the age rule.
    always_comb begin
      if (rot_mode) begin
        pick_valid = rot_hit;
        pick_tid   = rot_tid;
      end else begin
        pick_valid = age_hit;
        pick_tid   = age_tid;
      end
    end
  end

endmodule

// File: rtl/commit_thread_select_chk.sv
module commit_thread_select_chk #(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned SEQ_W       = 16,
  parameter int unsigned TID_W       = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [1:0]                   policy_sel,
  input logic [NUM_THREADS-1:0]       thread_active,
  input logic [3*NUM_THREADS-1:0]     thread_status,
  input logic [NUM_THREADS-1:0]       rob_empty,
  input logic [NUM_THREADS-1:0]       head_ready,
  input logic [SEQ_W*NUM_THREADS-1:0] head_seq,
  input logic                         select_stb,
  input logic                         pick_valid,
  input logic [TID_W-1:0]             pick_tid,
  input logic [NUM_THREADS*TID_W-1:0] rr_order_flat
);

  logic [2:0]             win_state;
  logic                   win_state_ok;
  logic                   rival_older;
  logic [NUM_THREADS-1:0] present;
  logic                   took_rot;

  assign win_state    = thread_status[int'(pick_tid)*3 +: 3];
  assign win_state_ok = (win_state == 3'd0) || (win_state == 3'd1) || (win_state == 3'd4);
  assign took_rot     = select_stb && pick_valid && (policy_sel == 2'd1);

  always_comb begin
    rival_older = 1'b0;
    for (int k = 0; k < NUM_THREADS; k++) begin
      if (thread_active[k] && head_ready[k] && !rob_empty[k] &&
          ((thread_status[k*3 +: 3] == 3'd0) || (thread_status[k*3 +: 3] == 3'd1) ||
           (thread_status[k*3 +: 3] == 3'd4))) begin
        if ((head_seq[k*SEQ_W +: SEQ_W] < head_seq[int'(pick_tid)*SEQ_W +: SEQ_W]) ||
            ((head_seq[k*SEQ_W +: SEQ_W] == head_seq[int'(pick_tid)*SEQ_W +: SEQ_W]) &&
             (k < int'(pick_tid))))
          rival_older = 1'b1;
      end
    end
  end

  always_comb begin
    present = '0;
    for (int k = 0; k < NUM_THREADS; k++)
      present[rr_order_flat[k*TID_W +: TID_W]] = 1'b1;
  end

  assert_pick_usable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> win_state_ok);

  assert_pick_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> thread_active[pick_tid]);

  assert_none_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pick_valid |-> (pick_tid == '0));

  assert_order_perm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(present) == NUM_THREADS);

  assert_order_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !took_rot |=> $stable(rr_order_flat));

  if (NUM_THREADS > 1) begin : g_multi_chk
    assert_rot_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pick_valid && policy_sel == 2'd1) |-> head_ready[pick_tid]);

    // Also covers the lower-index tie rule of R7.
    assert_age_oldest_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pick_valid && policy_sel != 2'd1) |-> (!rob_empty[pick_tid] && !rival_older));
  end

endmodule

bind commit_thread_select commit_thread_select_chk #(
  .NUM_THREADS(NUM_THREADS), .SEQ_W(SEQ_W), .TID_W(TID_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .policy_sel    (policy_sel),
  .thread_active (thread_active),
  .thread_status (thread_status),
  .rob_empty     (rob_empty),
  .head_ready    (head_ready),
  .head_seq      (head_seq),
  .select_stb    (select_stb),
  .pick_valid    (pick_valid),
  .pick_tid      (pick_tid),
  .rr_order_flat (rr_order_flat)
);

// File: tb/commit_thread_select_test.sv
module commit_thread_select_test;

  localparam int NT  = 4;
  localparam int SW  = 8;
  localparam int NV  = 13;
  localparam int VW  = 65;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    policy_sel = 2'd1;
  logic [NT-1:0] thread_active = '1;
  logic [3*NT-1:0] thread_status = {4{3'd1}};
  logic [NT-1:0] rob_empty = '0;
  logic [NT-1:0] head_ready = '1;
  logic [SW*NT-1:0] head_seq = '0;
  logic          select_stb = 1'b0;
  logic          pick_valid;
  logic [1:0]    pick_tid;

  logic       s_active = 1'b0;
  logic [2:0] s_status = 3'd1;
  logic       s_empty = 1'b1;
  logic       s_ready = 1'b0;
  logic       s_valid;
  logic       s_tid;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  commit_thread_select #(.NUM_THREADS(NT), .SEQ_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel), .thread_active(thread_active),
    .thread_status(thread_status), .rob_empty(rob_empty), .head_ready(head_ready),
    .head_seq(head_seq), .select_stb(select_stb), .pick_valid(pick_valid),
    .pick_tid(pick_tid)
  );

  commit_thread_select #(.NUM_THREADS(1), .SEQ_W(SW)) uut1 (
    .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel), .thread_active(s_active),
    .thread_status(s_status), .rob_empty(s_empty), .head_ready(s_ready),
    .head_seq(8'd0), .select_stb(select_stb), .pick_valid(s_valid),
    .pick_tid(s_tid)
  );

  // {req(4), mode(2), active(4), states t3..t0 (12), empty(4), ready(4),
  //  seq t3..t0 (32), exp_valid(1), exp_tid(2)}
  localparam logic [VW-1:0] VECS [0:NV-1] = '{
    // R6: plain age order
    {4'd6, 2'd2, 4'hF, {3'd1,3'd1,3'd1,3'd1}, 4'h0, 4'hF, {8'd40,8'd30,8'd20,8'd10}, 1'b1, 2'd0},
    {4'd6, 2'd2, 4'hF, {3'd1,3'd1,3'd1,3'd1}, 4'h0, 4'hF, {8'd5,8'd30,8'd7,8'd10},   1'b1, 2'd3},
    {4'd6, 2'd2, 4'hF, {3'd1,3'd1,3'd1,3'd1}, 4'h0, 4'h7, {8'd5,8'd30,8'd7,8'd10},   1'b1, 2'd1},
    {4'd6, 2'd2, 4'hF, {3'd1,3'd1,3'd1,3'd1}, 4'h2, 4'h7, {8'd5,8'd30,8'd7,8'd10},   1'b1, 2'd0},
    // R7: equal sequence numbers
    {4'd7, 2'd2, 4'hF, {3'd1,3'd1,3'd1,3'd1}, 4'h0, 4'hF, {8'd9,8'd9,8'd20,8'd20},   1'b1, 2'd2},
    // R1: squashing and trap-pending threads skipped; idle and fetch-trap usable
    {4'd1, 2'd2, 4'hF, {3'd1,3'd2,3'd1,3'd1}, 4'h0, 4'hF, {8'd9,8'd9,8'd20,8'd20},   1'b1, 2'd3},
    {4'd1, 2'd2, 4'hF, {3'd3,3'd2,3'd0,3'd4}, 4'h0, 4'hF, {8'd9,8'd9,8'd20,8'd20},   1'b1, 2'd0},
    // R2: inactive threads excluded
    {4'd2, 2'd2, 4'h3, {3'd1,3'd1,3'd1,3'd1}, 4'h0, 4'hF, {8'd1,8'd2,8'd3,8'd4},     1'b1, 2'd1},
    // R8: greedy and spare code follow age
    {4'd8, 2'd0, 4'hF, {3'd1,3'd1,3'd1,3'd1}, 4'h0, 4'hF, {8'd5,8'd30,8'd7,8'd10},   1'b1, 2'd3},
    {4'd8, 2'd3, 4'hF, {3'd1,3'd1,3'd1,3'd1}, 4'h0, 4'hF, {8'd5,8'd30,8'd7,8'd10},   1'b1, 2'd3},
    // R9: nothing qualifies
    {4'd9, 2'd2, 4'hF, {3'd2,3'd2,3'd2,3'd2}, 4'h0, 4'hF, {8'd5,8'd30,8'd7,8'd10},   1'b0, 2'd0},
    {4'd9, 2'd2, 4'h0, {3'd1,3'd1,3'd1,3'd1}, 4'h0, 4'hF, {8'd5,8'd30,8'd7,8'd10},   1'b0, 2'd0},
    {4'd9, 2'd1, 4'hF, {3'd1,3'd1,3'd1,3'd1}, 4'h0, 4'h0, {8'd5,8'd30,8'd7,8'd10},   1'b0, 2'd0}
  };

  task automatic check(input string tag, input logic gv, input logic [1:0] gt,
                       input logic ev, input logic [1:0] et);
    total++;
    if (gv !== ev || gt !== et) begin
      bad++;
      $display("FAIL %s: got valid=%0b tid=%0d, expected valid=%0b tid=%0d",
               tag, gv, gt, ev, et);
    end
  endtask

  task automatic drive(input logic [1:0] pol, input logic [3:0] act,
                       input logic [3:0] rdy, input logic stb);
    @(negedge clk);
    policy_sel    = pol;
    thread_active = act;
    head_ready    = rdy;
    select_stb    = stb;
    #1;
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state of the ordering (R3): thread 0 first.
    drive(2'd1, 4'hF, 4'hF, 1'b0);
    check("R3 reset order", pick_valid, pick_tid, 1'b1, 2'd0);
    drive(2'd1, 4'hF, 4'hF, 1'b0);
    check("R5 no strobe", pick_valid, pick_tid, 1'b1, 2'd0);

    // Take thread 0: ordering 1,2,3,0 (R4).
    drive(2'd1, 4'hF, 4'hF, 1'b1);
    drive(2'd1, 4'hF, 4'hF, 1'b0);
    check("R4 move to back", pick_valid, pick_tid, 1'b1, 2'd1);
    // Take thread 1: ordering 2,3,0,1.
    drive(2'd1, 4'hF, 4'hF, 1'b1);
    drive(2'd1, 4'hF, 4'hF, 1'b0);
    check("R4 second take", pick_valid, pick_tid, 1'b1, 2'd2);
    // Thread 2 not ready: scan reaches thread 3 (R3).
    drive(2'd1, 4'hF, 4'hB, 1'b0);
    check("R3 skip unready", pick_valid, pick_tid, 1'b1, 2'd3);
    // Take thread 3 from the middle: ordering 2,0,1,3.
    drive(2'd1, 4'hF, 4'hB, 1'b1);
    drive(2'd1, 4'hF, 4'hF, 1'b0);
    check("R4 middle removal", pick_valid, pick_tid, 1'b1, 2'd2);
    drive(2'd1, 4'hF, 4'h3, 1'b0);
    check("R4 middle order", pick_valid, pick_tid, 1'b1, 2'd0);
    // Strobe with no winner leaves the ordering alone (R5).
    drive(2'd1, 4'hF, 4'h0, 1'b1);
    check("R9 rotate none", pick_valid, pick_tid, 1'b0, 2'd0);
    drive(2'd1, 4'hF, 4'hF, 1'b0);
    check("R5 strobe no winner", pick_valid, pick_tid, 1'b1, 2'd2);
    // Strobe under age mode leaves the ordering alone (R5).
    head_seq = {8'd4, 8'd3, 8'd2, 8'd1};
    drive(2'd2, 4'hF, 4'hF, 1'b1);
    check("R6 age pick", pick_valid, pick_tid, 1'b1, 2'd0);
    drive(2'd1, 4'hF, 4'hF, 1'b0);
    check("R5 age strobe", pick_valid, pick_tid, 1'b1, 2'd2);
    // Inactive thread 2 in rotating mode (R2): ordering 2,0,1,3 -> thread 0.
    drive(2'd1, 4'hB, 4'hF, 1'b0);
    check("R2 rotate inactive", pick_valid, pick_tid, 1'b1, 2'd0);

    // Reset restores the initial ordering (R3).
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(2'd1, 4'hF, 4'hF, 1'b0);
    check("R3 order after reset", pick_valid, pick_tid, 1'b1, 2'd0);

    // Table walk of the stateless modes.
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VECS[i];
      @(negedge clk);
      select_stb    = 1'b0;
      policy_sel    = v[60:59];
      thread_active = v[58:55];
      thread_status = v[54:43];
      rob_empty     = v[42:39];
      head_ready    = v[38:35];
      head_seq      = v[34:3];
      #1;
      check($sformatf("R%0d vector %0d", v[64:61], i), pick_valid, pick_tid,
            v[2], v[1:0]);
    end

    // Single-thread build (R10).
    @(negedge clk);
    s_active = 1'b1; s_status = 3'd1; s_empty = 1'b1; s_ready = 1'b0;
    #1;
    check("R10 single ignores ready", s_valid, {1'b0, s_tid}, 1'b1, 2'd0);
    @(negedge clk);
    s_status = 3'd4;
    #1;
    check("R10 single fetch trap", s_valid, {1'b0, s_tid}, 1'b1, 2'd0);
    @(negedge clk);
    s_status = 3'd2;
    #1;
    check("R10 single squashing", s_valid, {1'b0, s_tid}, 1'b0, 2'd0);
    @(negedge clk);
    s_status = 3'd1; s_active = 1'b0;
    #1;
    check("R10 single inactive", s_valid, {1'b0, s_tid}, 1'b0, 2'd0);

    done = 1;
    finish_run();
  end

endmodule